// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings an asynchronous DRAM array from power-up to normal service and then keeps its contents alive. After reset it stays silent for the required power-up pause. It then runs a fixed number of warm-up refresh cycles and raises a ready flag. From that point on it schedules one refresh per row interval, so every row is visited within the retention period.

Each refresh uses the CAS-before-RAS form. The DRAM's own row counter picks the row, so no address is driven. Address, OE and data are don't-care for the memory during these cycles, and the data pins stay open. The sequencer shares the RAS, CAS and W lines with an access sequencer through a request/grant pair. It raises a request, starts a cycle only when the grant is high, and keeps the request up until the cycle has finished. If the grant is withheld, due refreshes pile up in a saturating counter. When the grant returns, the owed refreshes are issued back to back.

All timing is given in nanoseconds as parameters and converted into clock cycles, rounded up. The clock period is also a parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, bus_req_o and init_done_o are 0, and ras_n_o, cas_n_o and we_n_o are 1.
- R2: After reset is released, the block leaves all strobes inactive and bus_req_o low for exactly PAUSE_NS/CLK_PERIOD_NS cycles (rounded up). bus_req_o rises in the cycle after that count.
- R3: init_done_o rises only after WARM_CNT refresh cycles have completed. It rises when the last warm-up cycle's precharge ends, with ras_n_o high, and it stays high until reset.
- R4: In every refresh, cas_n_o goes low before ras_n_o falls, for at least the CAS setup time (rounded up to whole cycles). cas_n_o stays low for the CAS hold time after ras_n_o falls, and it is released while ras_n_o is still low.
- R5: we_n_o is 1 at all times, so no refresh can be read as a test-mode entry.
- R6: ras_n_o stays low for exactly the RAS pulse time in cycles. Two RAS falls are never closer than the refresh cycle time in cycles.
- R7: Once init_done_o is high, one refresh becomes due every (RETENTION_NS/ROWS)/CLK_PERIOD_NS cycles (rounded down). The first request appears that many cycles after init_done_o rises.
- R8: A refresh cycle starts only in a cycle where bus_grant_i is high. With the grant low, the strobes stay inactive even though refreshes are due.
- R9: bus_req_o is high whenever ras_n_o or cas_n_o is low.
- R10: The count of owed refreshes saturates at OWED_MAX. Holding the grant low for more than OWED_MAX intervals yields exactly OWED_MAX refreshes once granted.
- R11: While more refreshes are owed and the grant stays high, the next cycle starts directly after the current precharge. RAS falls are then spaced by exactly the refresh cycle time.
- R12: A refresh that falls due in the same cycle that a refresh completes is counted. This also holds when the owed count is at OWED_MAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_o | output | 1 | Request for the shared DRAM strobes |
| bus_grant_i | input | 1 | Strobes granted by the access sequencer |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low (held high) |
| init_done_o | output | 1 | Power-up pause and warm-up refreshes complete |

## Verification
Two events can fall on the same clock edge: the interval counter making a refresh due, and the cycle engine retiring a refresh. The bench holds the grant low until the owed count is saturated. Using the known interval phase, it then raises the grant exactly one refresh cycle before the next interval expiry, so the first completion and the new due refresh land on the same edge. It judges the result only at the pins, by counting RAS falls until the request drops: it expects one more than the saturation limit. A plain saturation run with no collision is used as the contrast and must yield exactly the limit.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    CY_IDLE,
    CY_CSR,
    CY_RCAS,
    CY_RAS,
    CY_PRE
  } cyc_state_e;

  // ceil(a/b), never below one cycle
  function automatic int ns2cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int PAUSE_CYC = 20000,
  parameter int REFI_CYC  = 1562,
  localparam int PW = $clog2(PAUSE_CYC + 1),
  localparam int IW = $clog2(REFI_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic pause_done_o,
  output logic tick_o
);

  logic [PW-1:0] pause_q;
  logic          pause_done_q;
  logic [IW-1:0] intv_q;
  logic          intv_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_q      <= '0;
      pause_done_q <= 1'b0;
    end else if (!pause_done_q) begin
      if (pause_q == PW'(PAUSE_CYC - 1)) pause_done_q <= 1'b1;
      else                                pause_q      <= pause_q + 1'b1;
    end
  end

  assign intv_end = (intv_q == IW'(REFI_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    intv_q <= '0;
    else if (run_i) intv_q <= intv_end ? '0 : intv_q + 1'b1;
  end

  assign pause_done_o = pause_done_q;
  assign tick_o       = run_i & intv_end;

endmodule

// File: rtl/dram_ref_owed.sv
module dram_ref_owed #(
  parameter int OWED_MAX = 8,
  localparam int OW = $clog2(OWED_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          take_i,
  output logic [OW-1:0] owed_o,
  output logic          pend_o,
  output logic          more_o
);

  logic [OW-1:0] owed_q, owed_d;

  always_comb begin
    owed_d = owed_q;
    unique case ({tick_i, take_i})
      2'b10:   if (owed_q != OW'(OWED_MAX)) owed_d = owed_q + 1'b1;
      2'b01:   if (owed_q != '0) owed_d = owed_q - 1'b1;
      default: owed_d = owed_q; // both or neither: net zero
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else         owed_q <= owed_d;
  end

  assign owed_o = owed_q;
  assign pend_o = (owed_q != '0);
  // still owed after the cycle now retiring
  assign more_o = (owed_q > OW'(1)) | tick_i;

endmodule

// File: rtl/dram_ref_warm.sv
module dram_ref_warm #(
  parameter int WARM_CNT = 8,
  localparam int WW = $clog2(WARM_CNT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  output logic pend_o,
  output logic more_o,
  output logic init_done_o
);

  logic [WW-1:0] left_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= WW'(WARM_CNT);
      ready_q <= 1'b0;
    end else if (done_i && !ready_q) begin
      left_q <= left_q - 1'b1;
      if (left_q == WW'(1)) ready_q <= 1'b1;
    end
  end

  assign pend_o      = en_i & ~ready_q;
  assign more_o      = (left_q > WW'(1));
  assign init_done_o = ready_q;

endmodule

// File: rtl/dram_ref_engine.sv
module dram_ref_engine
  import dram_ref_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int CHR_CYC = 1,
  parameter int RAS_CYC = 5,
  parameter int RP_CYC  = 3,
  localparam int RLO_CYC = (RAS_CYC > CHR_CYC) ? RAS_CYC - CHR_CYC : 1,
  localparam int TW      = $clog2(CSR_CYC + CHR_CYC + RLO_CYC + RP_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic more_i,
  input  logic gnt_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic busy_o,
  output logic done_o
);

  cyc_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          ras_n_q, cas_n_q;
  logic          last;

  assign last = (tmr_q == '0);

  always_comb begin
    st_d  = st_q;
    tmr_d = last ? tmr_q : tmr_q - 1'b1;
    unique case (st_q)
      CY_IDLE: if (want_i && gnt_i) begin
        st_d  = CY_CSR;
        tmr_d = TW'(CSR_CYC - 1);
      end
      CY_CSR: if (last) begin
        st_d  = CY_RCAS;
        tmr_d = TW'(CHR_CYC - 1);
      end
      CY_RCAS: if (last) begin
        st_d  = CY_RAS;
        tmr_d = TW'(RLO_CYC - 1);
      end
      CY_RAS: if (last) begin
        st_d  = CY_PRE;
        tmr_d = TW'(RP_CYC - 1);
      end
      CY_PRE: if (last) begin
        if (more_i && gnt_i) begin
          st_d  = CY_CSR;
          tmr_d = TW'(CSR_CYC - 1);
        end else begin
          st_d  = CY_IDLE;
        end
      end
      default: st_d = CY_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= CY_IDLE;
      tmr_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      // strobes from flops, decoded from the next state
      ras_n_q <= !(st_d == CY_RCAS || st_d == CY_RAS);
      cas_n_q <= !(st_d == CY_CSR  || st_d == CY_RCAS);
    end
  end

  assign ras_n_o = ras_n_q;
  assign cas_n_o = cas_n_q;
  assign we_n_o  = 1'b1;
  assign busy_o  = (st_q != CY_IDLE);
  assign done_o  = (st_q == CY_PRE) && last;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int PAUSE_NS      = 200_000,
  parameter int RETENTION_NS  = 32_000_000,
  parameter int ROWS          = 2048,
  parameter int WARM_CNT      = 8,
  parameter int OWED_MAX      = 8,
  parameter int CSR_NS        = 10,
  parameter int CHR_NS        = 8,
  parameter int RAS_NS        = 50,
  parameter int RP_NS         = 30,
  parameter int RC_NS         = 90,
  localparam int PAUSE_CYC = ns2cyc(PAUSE_NS, CLK_PERIOD_NS),
  localparam int REFI_RAW  = (RETENTION_NS / ROWS) / CLK_PERIOD_NS,
  localparam int REFI_CYC  = (REFI_RAW < 1) ? 1 : REFI_RAW,
  localparam int CSR_CYC   = ns2cyc(CSR_NS, CLK_PERIOD_NS),
  localparam int CHR_CYC   = ns2cyc(CHR_NS, CLK_PERIOD_NS),
  localparam int RAS_CYC   = ns2cyc(RAS_NS, CLK_PERIOD_NS),
  localparam int RC_CYC    = ns2cyc(RC_NS, CLK_PERIOD_NS),
  localparam int RP_MIN    = ns2cyc(RP_NS, CLK_PERIOD_NS),
  localparam int RP_FILL   = RC_CYC - RAS_CYC - CSR_CYC,
  localparam int RP_CYC    = (RP_FILL > RP_MIN) ? RP_FILL : RP_MIN,
  localparam int OW        = $clog2(OWED_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bus_req_o,
  input  logic bus_grant_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic init_done_o
);

  logic          pause_done, tick, init_done;
  logic          warm_pend, warm_more, owed_pend, owed_more;
  logic          want, more, busy, done;
  logic [OW-1:0] owed_q;

  dram_ref_timer #(
    .PAUSE_CYC(PAUSE_CYC),
    .REFI_CYC (REFI_CYC)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (init_done),
    .pause_done_o(pause_done),
    .tick_o      (tick)
  );

  dram_ref_warm #(.WARM_CNT(WARM_CNT)) u_warm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (pause_done),
    .done_i     (done & ~init_done),
    .pend_o     (warm_pend),
    .more_o     (warm_more),
    .init_done_o(init_done)
  );

  dram_ref_owed #(.OWED_MAX(OWED_MAX)) u_owed (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .take_i(done & init_done),
    .owed_o(owed_q),
    .pend_o(owed_pend),
    .more_o(owed_more)
  );

  assign want = warm_pend | owed_pend;
  assign more = init_done ? owed_more : warm_more;

  dram_ref_engine #(
    .CSR_CYC(CSR_CYC),
    .CHR_CYC(CHR_CYC),
    .RAS_CYC(RAS_CYC),
    .RP_CYC (RP_CYC)
  ) u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .want_i (want),
    .more_i (more),
    .gnt_i  (bus_grant_i),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o),
    .we_n_o (we_n_o),
    .busy_o (busy),
    .done_o (done)
  );

  assign bus_req_o   = want | busy;
  assign init_done_o = init_done;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int RAS_CYC  = 5,
  parameter int OWED_MAX = 8,
  parameter int OW       = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_grant_i,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          we_n_o,
  input logic          init_done_o,
  input logic [OW-1:0] owed_q
);

  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt <= '0;
    else if (!ras_n_o) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  a_r2_quiet_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && !bus_req_o) |-> (ras_n_o && cas_n_o));

  a_r3_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  a_r4_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  a_r4_cas_freed_in_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> !ras_n_o);

  a_r5_we_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_n_o);

  a_r6_ras_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (low_cnt == 16'(RAS_CYC)));

  a_r8_start_on_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> $past(bus_grant_i));

  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> bus_req_o);

  a_r10_owed_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= OW'(OWED_MAX));

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .RAS_CYC (RAS_CYC),
  .OWED_MAX(OWED_MAX),
  .OW      (OW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_o  (bus_req_o),
  .bus_grant_i(bus_grant_i),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .init_done_o(init_done_o),
  .owed_q     (owed_q)
);

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;

  localparam int CLK_NS    = 10;
  localparam int PAUSE_NS  = 3000;
  localparam int RET_NS    = 16000;
  localparam int ROWS      = 8;
  localparam int WARM      = 8;
  localparam int OMAX      = 8;
  localparam int PAUSE_CYC = 300;   // 3000/10
  localparam int REFI      = 200;   // 16000/8/10
  localparam int RAS_CYC   = 5;     // 50 ns
  localparam int TRC       = 9;     // 90 ns

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_grant_i = 1'b0;
  logic bus_req_o, ras_n_o, cas_n_o, we_n_o, init_done_o;

  int checks = 0;
  int fails  = 0;
  int nc     = 0;   // posedges seen
  int falls  = 0;
  int last_fall = 0;
  int low_run = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1;
  bit burst_mode = 1'b0, burst_seen = 1'b0;
  int nc_done, t0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  dram_refresh_seq #(
    .CLK_PERIOD_NS(CLK_NS),
    .PAUSE_NS     (PAUSE_NS),
    .RETENTION_NS (RET_NS),
    .ROWS         (ROWS),
    .WARM_CNT     (WARM),
    .OWED_MAX     (OMAX)
  ) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_req_o  (bus_req_o),
    .bus_grant_i(bus_grant_i),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .we_n_o     (we_n_o),
    .init_done_o(init_done_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", rq, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) nc <= nc + 1;

  // pin monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_ras && !ras_n_o) begin
        falls++;
        chk(prev_cas == 1'b0 && cas_n_o == 1'b0, "R4 cas low around ras fall", int'(cas_n_o), 0);
        chk(we_n_o == 1'b1, "R5 we high", int'(we_n_o), 1);
        chk(bus_req_o == 1'b1, "R9 req held", int'(bus_req_o), 1);
        if (falls > 1) chk(nc - last_fall >= TRC, "R6 ras spacing", nc - last_fall, TRC);
        if (burst_mode && burst_seen) chk(nc - last_fall == TRC, "R11 back-to-back spacing", nc - last_fall, TRC);
        if (burst_mode) burst_seen = 1'b1;
        last_fall = nc;
      end
      if (!ras_n_o) low_run++;
      else begin
        if (!prev_ras) chk(low_run == RAS_CYC, "R6 ras low width", low_run, RAS_CYC);
        low_run = 0;
      end
      if ((!ras_n_o || !cas_n_o) && !bus_req_o) chk(1'b0, "R9 req dropped in cycle", 0, 1);
      prev_ras = ras_n_o;
      prev_cas = cas_n_o;
    end
  end

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic wait_nc(input int target);
    while (nc < target) step();
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk(bus_req_o == 1'b0, "R1 req in reset", int'(bus_req_o), 0);
    chk(init_done_o == 1'b0, "R1 done in reset", int'(init_done_o), 0);
    chk(ras_n_o && cas_n_o, "R1 ras/cas in reset", int'({ras_n_o, cas_n_o}), 3);
    chk(we_n_o == 1'b1, "R1 we in reset", int'(we_n_o), 1);
  endtask

  task automatic t_pause();
    int n = 0;
    bus_grant_i = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    while (!bus_req_o && n < PAUSE_CYC + 50) begin
      step();
      n++;
    end
    chk(n == PAUSE_CYC, "R2 pause length", n, PAUSE_CYC);
    chk(falls == 0, "R2 no strobes during pause", falls, 0);
  endtask

  task automatic t_warmup();
    int n = 0;
    while (!init_done_o && n < 500) begin
      step();
      n++;
    end
    bus_grant_i = 1'b0;
    nc_done = nc;
    chk(falls == WARM, "R3 warm-up count at ready", falls, WARM);
    chk(ras_n_o == 1'b1, "R3 ras high at ready", int'(ras_n_o), 1);
  endtask

  task automatic t_interval();
    int f0 = falls;
    int n = 0;
    while (!bus_req_o && n < REFI + 50) begin
      step();
      n++;
    end
    t0 = nc;
    chk(t0 - nc_done == REFI, "R7 first refresh interval", t0 - nc_done, REFI);
    chk(init_done_o == 1'b1, "R3 ready stays", int'(init_done_o), 1);
    repeat (20) step();
    chk(falls == f0 && ras_n_o && cas_n_o, "R8 no cycle without grant", falls - f0, 0);
  endtask

  task automatic burst(input int target, input int expn, input string rq);
    int f0, n;
    wait_nc(target);
    f0 = falls;
    burst_mode = 1'b1;
    burst_seen = 1'b0;
    bus_grant_i = 1'b1;
    n = 0;
    step();
    while (bus_req_o && n < 200) begin
      step();
      n++;
    end
    bus_grant_i = 1'b0;
    burst_mode = 1'b0;
    chk(falls - f0 == expn, rq, falls - f0, expn);
  endtask

  task automatic t_saturate();
    wait_nc(t0 + 9 * REFI + 4);
    chk(falls == WARM, "R8 strobes idle while owed", falls, WARM);
    burst(t0 + 9 * REFI + 5, OMAX, "R10 saturated owed count");
  endtask

  task automatic t_collide();
    // first completion lands on the edge of the next interval expiry
    burst(t0 + 18 * REFI - 10, OMAX + 1, "R12 due and retire same edge");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pause();
    t_warmup();
    t_interval();
    t_saturate();
    t_collide();
    repeat (5) step();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule